// File: doc/BRIEF.md
# Bit-parallel binary field multiplier

This block multiplies two elements of the binary extension field GF(2^M) held in polynomial basis and returns their product reduced modulo a fixed irreducible polynomial, all within one clock period. Field degree M and the lower coefficients of the reduction polynomial are elaboration parameters. The polynomial is monic of degree M, so only its terms below x^M are given.

The datapath has two stages. The first is a product-term stage built from AND/XOR inner products. It yields the M low coefficients of the unreduced product, which need no folding. It also yields the M-1 high coefficients, which do. A routing bus of exactly M-1 lines carries the high coefficients into M per-output XOR trees. Which high bit enters which tree follows from the reduction matrix. That matrix is derived from the polynomial parameter at elaboration, so no table is written by hand.

An optional result register with a clock enable can sit behind the trees. It is selected by parameter and is present by default.

Top module: `gf2m_mul`

## Requirements
- R1: With bit k of each vector being the coefficient of x^k and R(x) = x^M + sum of POLY[k]·x^k, the register captures a·b mod R(x) at every rising clock edge where en is 1, and c shows it after that edge.
- R2: For M=4 and POLY=4'b1001 (R(x)=x^4+x^3+1), all 256 operand pairs give the modular product; for example, a=4'h8 and b=4'h2 give c=4'h9.
- R3: If either operand is zero, the captured result is zero.
- R4: If a equals 1 (only bit 0 set), the captured result equals b.
- R5: The result is the same when a and b are swapped.
- R6: At a rising edge with en at 0, c keeps its previous value whatever a and b do.
- R7: While rst_n is 0, c is zero. This takes effect immediately, without a clock edge, and holds through edges where en is 1.
- R8: For M=8 and POLY=8'h1B, 8'h57 times 8'h83 gives 8'hC1, and 8'h57 times 8'h13 gives 8'hFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the result register |
| rst_n | input | 1 | Asynchronous active-low clear of the result |
| en | input | 1 | Capture enable of the result register |
| a | input | M | First operand, bit k = coefficient of x^k |
| b | input | M | Second operand, same encoding |
| c | output | M | Reduced product, same encoding |

## Verification
The checks assume that a and b are stable and fully known, with no X bits, around each rising edge where en is 1. They also assume that POLY describes an irreducible polynomial of degree M, so the reduction matrix is well formed. The bench drives operands only at falling edges and only with defined values, and it uses two known irreducible polynomials. Reset is asserted from time zero and is only released at a falling edge, so every clocked check begins after a defined capture.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;
  localparam int GF_MAXW = 256;

  // Coefficient j of x^(m+k) mod R(x), R(x) = x^m + low
  function automatic logic fold_bit(int m, logic [GF_MAXW-1:0] low, int k, int j);
    logic [GF_MAXW-1:0] row;
    logic               top;
    row = low;
    for (int s = 0; s < k; s++) begin
      top    = row[m-1];
      row    = row << 1;
      row[m] = 1'b0;
      if (top) row = row ^ low;
    end
    return row[j];
  endfunction

  // Column j of the reduction matrix: bit k set when high term k feeds output j
  function automatic logic [GF_MAXW-1:0] fold_col(int m, logic [GF_MAXW-1:0] low, int j);
    logic [GF_MAXW-1:0] col;
    col = '0;
    for (int k = 0; k < m - 1; k++) col[k] = fold_bit(m, low, k, j);
    return col;
  endfunction
endpackage

// File: rtl/gf2m_term_net.sv
module gf2m_term_net #(
  parameter int M = 4
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] lo_terms,
  output logic [M-2:0] hi_terms
);
  // Group i forms coefficient i (length i+1) and coefficient M+i (length M-1-i)
  for (genvar i = 0; i < M; i++) begin : g_grp
    logic lo_acc;
    always_comb begin
      lo_acc = 1'b0;
      for (int j = 0; j <= i; j++) lo_acc = lo_acc ^ (a[j] & b[i-j]);
    end
    assign lo_terms[i] = lo_acc;

    if (i < M - 1) begin : g_hi
      logic hi_acc;
      always_comb begin
        hi_acc = 1'b0;
        for (int j = i + 1; j < M; j++) hi_acc = hi_acc ^ (a[j] & b[M+i-j]);
      end
      assign hi_terms[i] = hi_acc;
    end
  end
endmodule

// File: rtl/gf2m_fold_net.sv
module gf2m_fold_net
  import gf2m_pkg::*;
#(
  parameter int           M    = 4,
  parameter logic [M-1:0] POLY = 4'b1001
) (
  input  logic [M-1:0] lo_terms,
  input  logic [M-2:0] hi_terms,
  output logic [M-1:0] prod
);
  localparam logic [GF_MAXW-1:0] POLY_W = GF_MAXW'(POLY);

  // One XOR tree per output bit, its taps taken from the reduction matrix column
  for (genvar j = 0; j < M; j++) begin : g_tree
    localparam logic [GF_MAXW-1:0] COL_W = fold_col(M, POLY_W, j);
    localparam logic [M-2:0]       TAPS  = COL_W[M-2:0];
    assign prod[j] = lo_terms[j] ^ (^(hi_terms & TAPS));
  end
endmodule

// File: rtl/gf2m_out_stage.sv
module gf2m_out_stage #(
  parameter int M       = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [M-1:0] prod,
  output logic [M-1:0] c
);
  if (OUT_REG) begin : g_reg
    logic [M-1:0] res_q;
    logic [M-1:0] res_nxt;

    always_comb begin
      res_nxt = res_q;
      if (en) res_nxt = prod;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= res_nxt;
    end

    assign c = res_q;
  end else begin : g_comb
    assign c = prod;
  end
endmodule

// File: rtl/gf2m_mul.sv
module gf2m_mul #(
  parameter int           M       = 4,
  parameter logic [M-1:0] POLY    = 4'b1001,
  parameter bit           OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] c
);
  logic [M-1:0] lo_w;
  logic [M-2:0] hi_w;
  logic [M-1:0] prod_w;

  gf2m_term_net #(.M(M)) u_terms (
    .a        (a),
    .b        (b),
    .lo_terms (lo_w),
    .hi_terms (hi_w)
  );

  gf2m_fold_net #(.M(M), .POLY(POLY)) u_fold (
    .lo_terms (lo_w),
    .hi_terms (hi_w),
    .prod     (prod_w)
  );

  gf2m_out_stage #(.M(M), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .prod  (prod_w),
    .c     (c)
  );
endmodule

// File: rtl/gf2m_mul_chk.sv
module gf2m_mul_chk #(
  parameter int M       = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [M-1:0] a,
  input logic [M-1:0] b,
  input logic [M-1:0] prod,
  input logic [M-1:0] c
);
  a_r3_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a == '0) |-> (prod == '0));

  a_r3_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (b == '0) |-> (prod == '0));

  a_r4_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (a == M'(1)) |-> (prod == b));

  if (OUT_REG) begin : g_reg_chk
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (c == $past(prod)));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(c));
  end
endmodule

bind gf2m_mul gf2m_mul_chk #(.M(M), .OUT_REG(OUT_REG)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (en),
  .a     (a),
  .b     (b),
  .prod  (prod_w),
  .c     (c)
);

// File: tb/gf2m_mul_bench.sv
module gf2m_mul_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [3:0] a4, b4, c4;
  logic [7:0] a8, b8, c8;
  int         total = 0;
  int         bad   = 0;
  bit         done  = 1'b0;

  always #10 clk = ~clk;

  gf2m_mul #(.M(4), .POLY(4'b1001), .OUT_REG(1'b1)) u_gf2m_mul (
    .clk(clk), .rst_n(rst_n), .en(en), .a(a4), .b(b4), .c(c4)
  );

  gf2m_mul #(.M(8), .POLY(8'h1B), .OUT_REG(1'b1)) u_gf2m_mul8 (
    .clk(clk), .rst_n(rst_n), .en(en), .a(a8), .b(b8), .c(c8)
  );

  function automatic logic [7:0] ref_mul(int m, logic [7:0] poly, logic [7:0] x, logic [7:0] y);
    logic [8:0] mk;
    logic [7:0] z;
    logic       cy;
    mk = (9'd1 << m) - 9'd1;
    z  = '0;
    for (int i = m - 1; i >= 0; i--) begin
      cy = z[m-1];
      z  = 8'((9'(z) << 1) & mk);
      if (cy)   z = z ^ poly;
      if (y[i]) z = z ^ x;
    end
    return z;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [3:0] x4, logic [3:0] y4, logic [7:0] x8, logic [7:0] y8);
    @(negedge clk);
    a4 = x4; b4 = y4; a8 = x8; b8 = y8; en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R7 reset c4", {4'h0, c4}, 8'h00);
    chk("R7 reset c8", c8, 8'h00);
  endtask

  task automatic t_exhaustive();
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        step(4'(x), 4'(y), 8'h00, 8'h00);
        chk("R1 R2 exhaustive", {4'h0, c4}, ref_mul(4, 8'h09, 8'(x), 8'(y)));
      end
    end
    step(4'h8, 4'h2, 8'h00, 8'h00);
    chk("R2 x^3*x", {4'h0, c4}, 8'h09);
  endtask

  task automatic t_zero();
    step(4'h0, 4'hB, 8'hA7, 8'h00);
    chk("R3 zero a", {4'h0, c4}, 8'h00);
    chk("R3 zero b", c8, 8'h00);
  endtask

  task automatic t_unit();
    step(4'h1, 4'hD, 8'h01, 8'hE5);
    chk("R4 unit 4", {4'h0, c4}, 8'h0D);
    chk("R4 unit 8", c8, 8'hE5);
  endtask

  task automatic t_commute();
    logic [7:0] x, y, r1;
    for (int n = 0; n < 20; n++) begin
      x = 8'($urandom);
      y = 8'($urandom);
      step(4'h0, 4'h0, x, y);
      r1 = c8;
      chk("R1 random 8", r1, ref_mul(8, 8'h1B, x, y));
      step(4'h0, 4'h0, y, x);
      chk("R5 swapped", c8, r1);
    end
  endtask

  task automatic t_known8();
    step(4'h0, 4'h0, 8'h57, 8'h83);
    chk("R8 57*83", c8, 8'hC1);
    step(4'h0, 4'h0, 8'h57, 8'h13);
    chk("R8 57*13", c8, 8'hFE);
  endtask

  task automatic t_hold();
    step(4'h3, 4'h5, 8'h57, 8'h83);
    chk("R1 load 4", {4'h0, c4}, 8'h0F);
    en = 1'b0;
    a4 = 4'h9; b4 = 4'h7; a8 = 8'h11; b8 = 8'h22;
    @(negedge clk);
    chk("R6 hold 4", {4'h0, c4}, 8'h0F);
    chk("R6 hold 8", c8, 8'hC1);
  endtask

  task automatic t_async();
    step(4'h3, 4'h5, 8'h57, 8'h13);
    en = 1'b0;
    #2 rst_n = 1'b0;
    #1;
    chk("R7 async 4", {4'h0, c4}, 8'h00);
    chk("R7 async 8", c8, 8'h00);
    en = 1'b1; a4 = 4'h7; b4 = 4'h6;
    @(negedge clk);
    chk("R7 held in reset", {4'h0, c4}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {4'h0, c4}, ref_mul(4, 8'h09, 8'h07, 8'h06));
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0;
    a4 = '0; b4 = '0; a8 = '0; b8 = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_exhaustive();
    t_zero();
    t_unit();
    t_commute();
    t_known8();
    t_hold();
    t_async();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule